// File: doc/BRIEF.md
# Asynchronous Read Slave with Acknowledge Handshake

This block lets an external processor read on-chip registers and memory over an asynchronous, strobe-based bus. The bus carries an active-low select, an active-low data strobe, a read flag, a space bit that picks registers or memory, a 20-bit word address, a 16-bit data path and an active-low acknowledge. All three control inputs are synchronised into the core clock before the block acts on them. Once both strobes are seen during a read, the block latches the address and space, issues a read to the register file or to the memory port, and drives the returned word onto the data path. It asserts acknowledge one clock later.

The data path and the acknowledge line each come with their own output enable, which drives the pad tristates. The acknowledge line is driven (high) for as long as the select is low, and it floats otherwise. The data path is driven only while a recognised read holds valid data. After a cycle ends, the select must stay high for a few clocks before another access is accepted.

Top module: `async_rd_slave`

## Requirements
- R1: A read is recognised only when select and strobe are both low and the read flag is high. While either strobe stays high, no request is issued, and acknowledge and data are never asserted.
- R2: A recognised cycle ends as soon as either strobe goes high. Data enable and acknowledge are released within three rising edges of that change, on the same clock as each other.
- R3: Within two rising edges of select going low, the acknowledge enable is set and acknowledge is driven high. It stays driven for as long as select is low. Acknowledge is low only while its enable is set.
- R4: The acknowledge enable clears within three rising edges of select going high. With select high for three consecutive edges, neither output enable is set.
- R5: The data enable is set and the data path holds the final word one clock before acknowledge goes low. Both are held while acknowledge stays low.
- R6: In a register read (space bit 0), the block pulses the register read strobe for one clock with the latched address. Acknowledge goes low on the 15th rising edge from the first edge that samples both strobes low, which is 13 clocks after they leave the synchroniser.
- R7: In a memory read (space bit 1), the memory request stays high until a ready is sampled. The word present with ready is returned. Acknowledge goes low one clock after the edge that samples ready, but never before the register-read latency of R6.
- R8: After a cycle ends, select must be high for three consecutive synchronised clocks before a new access is recognised. A shorter pulse on select, or re-asserting the strobe alone, starts nothing.
- R9: The request address equals the bus address presented when the cycle was recognised. At most one of the two read requests is active at a time.
- R10: With the read flag low (a write), both strobes low start no request and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_n | input | 1 | Bus select, active low, asynchronous |
| bus_strb_n | input | 1 | Bus data strobe, active low, asynchronous |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_space | input | 1 | 0 = register space, 1 = memory space |
| bus_addr | input | 20 | Word address |
| bus_dq | output | 16 | Read data toward the pad |
| bus_dq_oe | output | 1 | Data pad drive enable |
| bus_ack_n | output | 1 | Acknowledge level, active low |
| bus_ack_oe | output | 1 | Acknowledge pad drive enable |
| rd_addr | output | 20 | Latched address for internal reads |
| reg_rd | output | 1 | One-clock register read strobe |
| reg_rdata | input | 16 | Register word, valid in the reg_rd clock |
| mem_rd | output | 1 | Memory read request, held until ready |
| mem_ready | input | 1 | Memory data valid |
| mem_rdata | input | 16 | Memory word, valid with mem_ready |

## Verification
The fixed register latency and the one-clock lead of data over acknowledge make a stuck or skipped state visible on the acknowledge pin within one access. If the cycle is recognised late or early, or the wait counter is miscounted, the count of edges to acknowledge is off at once. If the gap counter or the end detection is wrong, a short select pulse or a re-asserted strobe starts a cycle it should not, and acknowledge falls tens of clocks into what should be a dead period. A wrong latched space or address appears on the request ports in the first waiting clock.

// File: rtl/async_rd_slave.sv
module async_rd_slave #(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int REG_WAIT    = 10,
  parameter int GAP_CLKS    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel_n,
  input  logic          bus_strb_n,
  input  logic          bus_rd,
  input  logic          bus_space,
  input  logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dq,
  output logic          bus_dq_oe,
  output logic          bus_ack_n,
  output logic          bus_ack_oe,
  output logic [AW-1:0] rd_addr,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata,
  output logic          mem_rd,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);

  localparam int CW = $clog2(REG_WAIT + 1);
  localparam int GW = $clog2(GAP_CLKS + 1);
  localparam int TS = SYNC_STAGES - 1;

  typedef enum logic [2:0] {S_IDLE, S_DECODE, S_WAIT_DATA, S_SETUP, S_ACK, S_GAP} st_t;

  st_t             state;
  logic [TS:0]     sel_sy, strb_sy, rd_sy;
  logic [CW-1:0]   wcnt;
  logic [GW-1:0]   gcnt;
  logic            got, space_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;

  wire sel_a    = !sel_sy[TS];
  wire strb_a   = !strb_sy[TS];
  wire end_now  = !(sel_a && strb_a);
  wire wait_ok  = (wcnt == CW'(REG_WAIT - 1));
  wire have     = !space_q || got || mem_ready;
  wire in_wait  = (state == S_WAIT_DATA) && !end_now;

  assign rd_addr    = addr_q;
  assign reg_rd     = in_wait && !space_q && wait_ok;
  assign mem_rd     = in_wait && space_q && !got;
  assign bus_dq     = data_q;
  assign bus_dq_oe  = (state == S_SETUP || state == S_ACK) && !end_now;
  assign bus_ack_n  = !((state == S_ACK) && !end_now);
  assign bus_ack_oe = sel_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sy  <= '1;
      strb_sy <= '1;
      rd_sy   <= '0;
    end else begin
      sel_sy  <= {sel_sy[TS-1:0], bus_sel_n};
      strb_sy <= {strb_sy[TS-1:0], bus_strb_n};
      rd_sy   <= {rd_sy[TS-1:0], bus_rd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wcnt    <= '0;
      gcnt    <= '0;
      got     <= 1'b0;
      space_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          gcnt <= '0;
          if (sel_a && strb_a && rd_sy[TS]) begin
            addr_q  <= bus_addr;
            space_q <= bus_space;
            state   <= S_DECODE;
          end
        end
        S_DECODE: begin
          wcnt  <= '0;
          got   <= 1'b0;
          state <= end_now ? S_GAP : S_WAIT_DATA;
        end
        S_WAIT_DATA: begin
          if (end_now) state <= S_GAP;
          else begin
            if (!wait_ok) wcnt <= wcnt + 1'b1;
            if (space_q && !got && mem_ready) begin
              got    <= 1'b1;
              data_q <= mem_rdata;
            end
            if (wait_ok && have) begin
              if (!space_q) data_q <= reg_rdata;
              state <= S_SETUP;
            end
          end
        end
        S_SETUP: state <= end_now ? S_GAP : S_ACK;
        S_ACK:   if (end_now) state <= S_GAP;
        S_GAP: begin
          if (sel_a) gcnt <= '0;
          else if (gcnt == GW'(GAP_CLKS - 1)) begin
            gcnt  <= '0;
            state <= S_IDLE;
          end else gcnt <= gcnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/async_rd_slave_chk.sv
module async_rd_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_sel_n,
  input logic bus_ack_n,
  input logic bus_ack_oe,
  input logic bus_dq_oe,
  input logic reg_rd,
  input logic mem_rd
);

  p_ack_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> bus_ack_oe);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_n && $past(bus_sel_n) && $past(bus_sel_n, 2)) |-> (!bus_ack_oe && !bus_dq_oe));

  p_ack_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> bus_dq_oe);

  p_data_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack_n) |-> $past(bus_dq_oe));

  p_single_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && mem_rd));

endmodule

bind async_rd_slave async_rd_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_ack_n(bus_ack_n),
  .bus_ack_oe(bus_ack_oe), .bus_dq_oe(bus_dq_oe), .reg_rd(reg_rd), .mem_rd(mem_rd)
);

// File: tb/async_rd_slave_test.sv
module async_rd_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        bus_sel_n = 1'b1, bus_strb_n = 1'b1, bus_rd = 1'b1, bus_space = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [15:0] bus_dq;
  logic        bus_dq_oe, bus_ack_n, bus_ack_oe;
  logic [19:0] rd_addr;
  logic        reg_rd, mem_rd;
  logic [15:0] reg_rdata;
  logic        mem_ready;
  logic [15:0] mem_rdata;

  async_rd_slave uut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_strb_n(bus_strb_n),
    .bus_rd(bus_rd), .bus_space(bus_space), .bus_addr(bus_addr),
    .bus_dq(bus_dq), .bus_dq_oe(bus_dq_oe), .bus_ack_n(bus_ack_n), .bus_ack_oe(bus_ack_oe),
    .rd_addr(rd_addr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .mem_rd(mem_rd), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  assign reg_rdata = rd_addr[15:0] ^ 16'hA5C3;

  int checks = 0, errors = 0;
  int mem_delay = 1, mcnt = 0, seen_req = 0, both_req = 0;
  logic [15:0] mem_word = '0;
  logic [19:0] seen_addr = '0;
  bit done = 0;

  function automatic int exp_lat(bit sp, int d);
    if (!sp) return 15;
    return (d + 5 > 15) ? d + 5 : 15;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (reg_rd || mem_rd) begin
        seen_req++;
        seen_addr = rd_addr;
      end
      if (reg_rd && mem_rd) both_req++;
      if (!mem_rd) begin
        mem_ready = 1'b0;
        mcnt = 0;
      end else if (!mem_ready) begin
        mcnt++;
        if (mcnt >= mem_delay) begin
          mem_ready = 1'b1;
          mem_rdata = mem_word;
        end
      end
    end
  end

  task automatic release_bus();
    bus_sel_n = 1'b1;
    bus_strb_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_dq_oe && bus_ack_n && !bus_ack_oe, "R2 R4 release",
        {bus_dq_oe, bus_ack_n, bus_ack_oe}, 3'b010);
    repeat (6) @(negedge clk);
  endtask

  task automatic do_read(bit sp, logic [19:0] a, int d, bit glitch);
    logic [15:0] exp;
    int n, en;
    bit p_oe;
    logic [15:0] p_dq;
    mem_delay = d;
    mem_word = 16'($urandom);
    exp = sp ? mem_word : (a[15:0] ^ 16'hA5C3);
    en = exp_lat(sp, d);
    @(negedge clk);
    seen_req = 0;
    bus_addr = a; bus_space = sp; bus_rd = 1'b1;
    bus_sel_n = 1'b0; bus_strb_n = 1'b0;
    n = 0; p_oe = 0; p_dq = '0;
    while (bus_ack_n && n < 300) begin
      p_oe = bus_dq_oe; p_dq = bus_dq;
      @(negedge clk);
      n++;
    end
    chk(n == en, sp ? "R7 memory latency" : "R6 register latency", n, en);
    chk(p_oe && p_dq == exp, "R5 data one clock before ack", {p_oe, p_dq}, {1'b1, exp});
    chk(seen_req > 0 && seen_addr == a, "R9 request address", seen_addr, a);
    if (!sp) chk(seen_req == 1, "R6 single register strobe", seen_req, 1);
    repeat (3) @(negedge clk);
    chk(!bus_ack_n && bus_dq_oe && bus_dq == exp, "R5 data held during ack",
        {bus_ack_n, bus_dq}, {1'b0, exp});
    if (glitch) begin
      bus_sel_n = 1'b1;
      @(negedge clk);
      bus_sel_n = 1'b0;
      seen_req = 0;
      repeat (40) @(negedge clk);
      chk(bus_ack_n && seen_req == 0, "R8 short select gap", {bus_ack_n, 8'(seen_req)}, 9'h100);
    end
    release_bus();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(!bus_ack_oe && !bus_dq_oe && bus_ack_n && !reg_rd && !mem_rd, "R4 reset state",
        {bus_ack_oe, bus_dq_oe, bus_ack_n, reg_rd, mem_rd}, 5'b00100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    bus_sel_n = 1'b0;
    seen_req = 0;
    repeat (2) @(negedge clk);
    chk(bus_ack_oe && bus_ack_n, "R3 ack driven high", {bus_ack_oe, bus_ack_n}, 2'b11);
    repeat (30) @(negedge clk);
    chk(bus_ack_oe && bus_ack_n && !bus_dq_oe && seen_req == 0, "R1 select alone",
        {bus_ack_n, bus_dq_oe, 8'(seen_req)}, 10'h200);
    release_bus();

    bus_strb_n = 1'b0;
    seen_req = 0;
    repeat (30) @(negedge clk);
    chk(!bus_ack_oe && bus_ack_n && seen_req == 0, "R1 strobe alone",
        {bus_ack_oe, bus_ack_n, 8'(seen_req)}, 10'h100);
    release_bus();

    bus_rd = 1'b0;
    bus_sel_n = 1'b0; bus_strb_n = 1'b0;
    seen_req = 0;
    repeat (30) @(negedge clk);
    chk(bus_ack_n && !bus_dq_oe && seen_req == 0, "R10 write ignored",
        {bus_ack_n, bus_dq_oe, 8'(seen_req)}, 10'h200);
    release_bus();
    bus_rd = 1'b1;

    do_read(1'b0, 20'h12345, 1, 1'b0);
    do_read(1'b1, 20'hABCDE, 1, 1'b0);
    do_read(1'b1, 20'h00007, 9, 1'b0);
    do_read(1'b1, 20'hFFFFF, 120, 1'b0);
    do_read(1'b0, 20'h0F0F0, 1, 1'b1);
    do_read(1'b0, 20'h00001, 1, 1'b0);

    mem_delay = 60;
    bus_addr = 20'h55555; bus_space = 1'b1;
    bus_sel_n = 1'b0; bus_strb_n = 1'b0;
    repeat (20) @(negedge clk);
    bus_strb_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_dq_oe && bus_ack_n && !mem_rd && bus_ack_oe, "R2 strobe abort",
        {bus_dq_oe, bus_ack_n, mem_rd, bus_ack_oe}, 4'b0101);
    repeat (10) @(negedge clk);
    bus_strb_n = 1'b0;
    seen_req = 0;
    repeat (80) @(negedge clk);
    chk(bus_ack_n && seen_req == 0, "R8 strobe reassert without gap",
        {bus_ack_n, 8'(seen_req)}, 9'h100);
    release_bus();

    for (int i = 0; i < 24; i++) begin
      bit sp = 1'($urandom);
      do_read(sp, 20'($urandom), 1 + int'($urandom % 110), 1'b0);
    end
    chk(both_req == 0, "R9 exclusive requests", both_req, 0);
    finish_run();
  end

  initial begin
    #600000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule